// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block runs an analog-to-digital converter through a programmed list of up to eight conversion slots. Each slot names an arbitrary converter channel. Once a start strobe is accepted, the sequencer goes through a fixed settling wait and then a programmable start delay. It then requests one conversion per slot, from slot 0 up to a stop index, with a programmable gap between requests. Each returned 10-bit code goes into that slot's result entry. At the end of the list a sticky done flag is raised, and it drives an interrupt output unless a mask is set.

The control fields arrive as plain input ports, fed by a register file elsewhere: enable, start, continuous, stop index, channel list, three delay codes, done mask and done clear. In continuous mode the sequencer waits a tail delay after the last slot and starts again at slot 0 without a new start strobe. The converter is reached through a request/valid handshake. Results are read through a registered read port that can map onto block RAM.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy, conv_req, done_flag and irq are all low.
- R2: While enable is low the block stays idle: a start pulse is ignored, busy stays low and no conversion is requested.
- R3: A start pulse with enable high launches a pass over slots 0..stop_idx in ascending order. For slot x, conv_chan equals slot_chan[4x+3:4x]. conv_req holds with a stable channel until conv_valid.
- R4: The code returned for slot x is stored in result entry x. Setting rd_slot = x gives that code on rd_data one clock later.
- R5: The first request follows the start by SYNC + d*STEP cycles, plus at most two cycles of overhead. STEP = CLK_HZ/25000 (40 us), SYNC = 3*CLK_HZ/100000 (30 us), and d is dly_first.
- R6: After a conversion completes and the pass is not finished, the next request follows the accepting clock by dly_gap*STEP cycles, plus at most two cycles.
- R7: With continuous high, the last conversion of a pass is followed by a wait of dly_tail*STEP cycles (plus at most two). The pass then restarts at slot 0 without a new start. If continuous is low when the last conversion completes, the block goes idle.
- R8: done_flag is set when the conversion of slot stop_idx completes, and it is set again at the end of every pass. It stays set until a done_clr pulse. When a set and a clear fall in the same cycle, the set wins.
- R9: irq is high exactly when done_flag is high and done_mask is low.
- R10: A start pulse that arrives while busy is ignored, and the pass in progress continues in order.
- R11: Dropping enable aborts at once: on the next cycle busy and conv_req are low, and done_flag is not set.
- R12: busy is high from the clock after an accepted start until the block returns to idle. A stop index of 7 converts all eight slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts and idles |
| start | input | 1 | Start strobe, one cycle |
| continuous | input | 1 | Loop over the list after the tail delay |
| stop_idx | input | 3 | Last slot of a pass |
| dly_first | input | 4 | Start delay code, 40 us per step |
| dly_gap | input | 4 | Inter-slot delay code |
| dly_tail | input | 4 | Post-pass delay code (continuous only) |
| slot_chan | input | 32 | Channel of slot x at bits [4x+3:4x] |
| done_mask | input | 1 | Blocks done_flag from irq |
| done_clr | input | 1 | Clears done_flag (write-one pulse) |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel for the current request |
| conv_valid | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result code |
| rd_slot | input | 3 | Result read address |
| rd_data | output | 10 | Result read data, one cycle latency |
| busy | output | 1 | Sequence in progress |
| done_flag | output | 1 | Sticky pass-complete flag |
| irq | output | 1 | Masked done interrupt |

## Verification
The completion of the last slot, which sets the done flag, can fall in the same cycle as a host clear of that flag. The bench provokes this by having its converter model drive done_clr in the very cycle it returns the final result of a single-slot pass. It then requires done_flag to read high on the following cycle. A second overlap, a start strobe that arrives while a pass is running, is judged by the scoreboard: a restart would show up as an out-of-order request for slot 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W = 4;
  localparam int DATA_W = 10;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DLY1,
    ST_REQ,
    ST_GAP,
    ST_TAIL
  } seq_state_t;
endpackage

// File: rtl/adc_seq_timer.sv
// Coarse delay timer: either a fixed settle count, or code * step cycles.
// A code of zero completes one cycle after the load.
module adc_seq_timer #(
  parameter int STEP_CYC = 2000,
  parameter int SYNC_CYC = 1500,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              load_sync,
  input  logic [CODE_W-1:0] code,
  output logic              fire
);
  localparam int MAXC  = (STEP_CYC > SYNC_CYC) ? STEP_CYC : SYNC_CYC;
  localparam int PRE_W = $clog2(MAXC + 1);
  localparam int STP_W = CODE_W + 1;

  logic             active;
  logic [PRE_W-1:0] pre;
  logic [STP_W-1:0] steps;

  assign fire = active && ((steps == '0) || (steps == STP_W'(1) && pre == '0));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      active <= 1'b0;
      pre    <= '0;
      steps  <= '0;
    end else if (load) begin
      active <= 1'b1;
      if (load_sync) begin
        pre   <= PRE_W'(SYNC_CYC - 1);
        steps <= STP_W'(1);
      end else begin
        pre   <= PRE_W'(STEP_CYC - 1);
        steps <= STP_W'(code);
      end
    end else if (active) begin
      if (fire) begin
        active <= 1'b0;
      end else if (pre == '0) begin
        pre   <= PRE_W'(STEP_CYC - 1);
        steps <= steps - STP_W'(1);
      end else begin
        pre <= pre - PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
// Per-slot result store: one write port, registered read port.
module adc_seq_results #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_seq_irq.sv
// Sticky completion flag with write-one clear; a set beats a clear.
module adc_seq_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  always_comb flag_nxt = set | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt & ~mask;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int CLK_HZ = 50_000_000,
  parameter int NSLOT  = 8,
  localparam int SLOT_W   = $clog2(NSLOT),
  localparam int CHAN_W   = adc_seq_pkg::CHAN_W,
  localparam int DATA_W   = adc_seq_pkg::DATA_W,
  localparam int CODE_W   = adc_seq_pkg::CODE_W,
  localparam int STEP_CYC = CLK_HZ / 25000,
  localparam int SYNC_CYC = (CLK_HZ * 3) / 100000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    start,
  input  logic                    continuous,
  input  logic [SLOT_W-1:0]       stop_idx,
  input  logic [CODE_W-1:0]       dly_first,
  input  logic [CODE_W-1:0]       dly_gap,
  input  logic [CODE_W-1:0]       dly_tail,
  input  logic [NSLOT*CHAN_W-1:0] slot_chan,
  input  logic                    done_mask,
  input  logic                    done_clr,
  output logic                    conv_req,
  output logic [CHAN_W-1:0]       conv_chan,
  input  logic                    conv_valid,
  input  logic [DATA_W-1:0]       conv_data,
  input  logic [SLOT_W-1:0]       rd_slot,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    busy,
  output logic                    done_flag,
  output logic                    irq
);
  import adc_seq_pkg::*;

  seq_state_t        state, st_n;
  logic [SLOT_W-1:0] slot, slot_n, slot_inc;
  logic [CHAN_W-1:0] chan_q, chan_n;
  logic              tmr_load, tmr_sync, tmr_fire;
  logic [CODE_W-1:0] tmr_code;
  logic              res_we, done_set;

  assign slot_inc = slot + SLOT_W'(1);

  always_comb begin
    st_n     = state;
    slot_n   = slot;
    chan_n   = chan_q;
    tmr_load = 1'b0;
    tmr_sync = 1'b0;
    tmr_code = '0;
    res_we   = 1'b0;
    done_set = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          st_n     = ST_SYNC;
          slot_n   = '0;
          tmr_load = 1'b1;
          tmr_sync = 1'b1;
        end
      end
      ST_SYNC: begin
        if (tmr_fire) begin
          st_n     = ST_DLY1;
          tmr_load = 1'b1;
          tmr_code = dly_first;
        end
      end
      ST_DLY1: begin
        if (tmr_fire) begin
          st_n   = ST_REQ;
          chan_n = slot_chan[0 +: CHAN_W];
        end
      end
      ST_REQ: begin
        if (conv_valid) begin
          res_we = 1'b1;
          if (slot == stop_idx) begin
            done_set = 1'b1;
            if (continuous) begin
              st_n     = ST_TAIL;
              tmr_load = 1'b1;
              tmr_code = dly_tail;
            end else begin
              st_n = ST_IDLE;
            end
          end else begin
            slot_n   = slot_inc;
            chan_n   = slot_chan[slot_inc*CHAN_W +: CHAN_W];
            st_n     = ST_GAP;
            tmr_load = 1'b1;
            tmr_code = dly_gap;
          end
        end
      end
      ST_GAP: begin
        if (tmr_fire) st_n = ST_REQ;
      end
      ST_TAIL: begin
        if (tmr_fire) begin
          if (continuous) begin
            st_n   = ST_REQ;
            slot_n = '0;
            chan_n = slot_chan[0 +: CHAN_W];
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (!enable) begin
      st_n     = ST_IDLE;
      tmr_load = 1'b0;
      res_we   = 1'b0;
      done_set = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      slot   <= '0;
      chan_q <= '0;
    end else begin
      state  <= st_n;
      slot   <= slot_n;
      chan_q <= chan_n;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign conv_req  = (state == ST_REQ);
  assign conv_chan = chan_q;

  adc_seq_timer #(
    .STEP_CYC(STEP_CYC),
    .SYNC_CYC(SYNC_CYC),
    .CODE_W  (CODE_W)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clear    (~enable),
    .load     (tmr_load),
    .load_sync(tmr_sync),
    .code     (tmr_code),
    .fire     (tmr_fire)
  );

  adc_seq_results #(
    .DEPTH (NSLOT),
    .DATA_W(DATA_W)
  ) u_res (
    .clk  (clk),
    .we   (res_we),
    .waddr(slot),
    .wdata(conv_data),
    .raddr(rd_slot),
    .rdata(rd_data)
  );

  adc_seq_irq u_irq (
    .clk (clk),
    .rst (rst),
    .set (done_set),
    .clr (done_clr),
    .mask(done_mask),
    .flag(done_flag),
    .irq (irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              start,
  input logic              done_clr,
  input logic              done_mask,
  input logic              conv_req,
  input logic              conv_valid,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              busy,
  input logic              done_flag,
  input logic              irq
);
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_req); // R11
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && enable && start) |=> busy); // R12
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_valid && enable) |=> conv_req); // R3
  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_valid && enable) |=> $stable(conv_chan)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !done_clr) |=> done_flag); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(conv_valid)); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(done_mask) |-> !irq); // R9
endmodule

bind adc_seq_top adc_seq_chk #(.CHAN_W(adc_seq_pkg::CHAN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .start     (start),
  .done_clr  (done_clr),
  .done_mask (done_mask),
  .conv_req  (conv_req),
  .conv_valid(conv_valid),
  .conv_chan (conv_chan),
  .busy      (busy),
  .done_flag (done_flag),
  .irq       (irq)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int STEP   = CLK_HZ / 25000;
  localparam int SYNC   = (CLK_HZ * 3) / 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, start = 1'b0, continuous = 1'b0;
  logic [2:0]  stop_idx = '0;
  logic [3:0]  dly_first = '0, dly_gap = '0, dly_tail = '0;
  logic [31:0] slot_chan = '0;
  logic        done_mask = 1'b0, done_clr = 1'b0;
  logic        conv_req, conv_valid = 1'b0;
  logic [3:0]  conv_chan;
  logic [9:0]  conv_data = '0;
  logic [2:0]  rd_slot = '0;
  logic [9:0]  rd_data;
  logic        busy, done_flag, irq;

  always #10 clk = ~clk;

  adc_seq_top #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .continuous(continuous), .stop_idx(stop_idx), .dly_first(dly_first),
    .dly_gap(dly_gap), .dly_tail(dly_tail), .slot_chan(slot_chan),
    .done_mask(done_mask), .done_clr(done_clr), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_valid(conv_valid), .conv_data(conv_data),
    .rd_slot(rd_slot), .rd_data(rd_data), .busy(busy),
    .done_flag(done_flag), .irq(irq)
  );

  typedef struct {int slot; int chan; bit last;} item_t;
  item_t q[$];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // driver-side counters
  int drv_cmp = 0, drv_bad = 0;
  // monitor-side counters
  int mon_cmp = 0, mon_bad = 0;
  // requests from driver to monitor
  int  clr_req = 0;
  bit  auto_clr = 0;
  bit  collide = 0;
  int  exp_res [8];

  task automatic dchk(bit ok, string req, int act, int exp);
    drv_cmp++;
    if (!ok) begin
      drv_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mchk(bit ok, string req, int act, int exp);
    mon_cmp++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor plus converter model
  int    clr_ack = 0, wait_cnt = -1, ref_cyc = 0, exp_lo = 0, conv_n = 0;
  bit    req_prev = 0, busy_prev = 0, post_chk = 0, cur_last = 0;
  int    cur_slot = 0;
  item_t it;
  always @(negedge clk) begin
    done_clr   = 1'b0;
    conv_valid = 1'b0;
    if (!rst) begin
      if (clr_req != clr_ack) begin
        done_clr = 1'b1;
        clr_ack++;
      end
      if (post_chk) begin
        post_chk = 0;
        mchk(done_flag == 1'b1, "R8 done set at pass end", int'(done_flag), 1);
        mchk(irq == !done_mask, "R9 irq follows mask", int'(irq), int'(!done_mask));
        if (auto_clr) done_clr = 1'b1;
      end
      if (busy && !busy_prev) begin
        ref_cyc = cyc;
        exp_lo  = SYNC + int'(dly_first) * STEP;
      end
      if (!conv_req) wait_cnt = -1;
      if (conv_req && !req_prev) begin
        mchk((cyc - ref_cyc) >= exp_lo && (cyc - ref_cyc) <= exp_lo + 2,
             "R5/R6/R7 request delay", cyc - ref_cyc, exp_lo);
        if (q.size() == 0) begin
          mchk(1'b0, "R3 unexpected request", int'(conv_chan), -1);
          cur_slot = 0;
          cur_last = 0;
        end else begin
          it = q.pop_front();
          mchk(int'(conv_chan) == it.chan, "R3 channel order", int'(conv_chan), it.chan);
          cur_slot = it.slot;
          cur_last = it.last;
        end
        wait_cnt = 2;
      end else if (conv_req && wait_cnt > 0) begin
        wait_cnt--;
      end else if (conv_req && wait_cnt == 0) begin
        conv_n++;
        conv_data  = {conv_chan, 6'(conv_n)};
        conv_valid = 1'b1;
        exp_res[cur_slot] = int'({conv_chan, 6'(conv_n)});
        ref_cyc = cyc + 1;
        exp_lo  = (cur_last ? int'(dly_tail) : int'(dly_gap)) * STEP;
        if (cur_last) begin
          post_chk = 1;
          if (collide) done_clr = 1'b1;
        end
        wait_cnt = -1;
      end
    end
    req_prev  = conv_req;
    busy_prev = busy;
  end

  task automatic push_pass(int stop);
    for (int i = 0; i <= stop; i++) begin
      item_t x;
      x.slot = i;
      x.chan = int'(slot_chan[i*4 +: 4]);
      x.last = (i == stop);
      q.push_back(x);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic clear_done();
    clr_req++;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_results(int stop, string req);
    for (int i = 0; i <= stop; i++) begin
      @(negedge clk) rd_slot = 3'(i);
      @(negedge clk);
      dchk(int'(rd_data) == exp_res[i], req, int'(rd_data), exp_res[i]);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) slot_chan[i*4 +: 4] = 4'((i * 5 + 3) & 15);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    dchk(busy == 0 && conv_req == 0, "R1 reset busy/req", int'({busy, conv_req}), 0);
    dchk(done_flag == 0 && irq == 0, "R1 reset done/irq", int'({done_flag, irq}), 0);

    // R2: start with enable low
    pulse_start();
    repeat (100) @(negedge clk);
    dchk(busy == 0, "R2 disabled start ignored", int'(busy), 0);

    // Short pass, start delay, unmasked
    enable = 1'b1; stop_idx = 3'd2; dly_first = 4'd1; dly_gap = 4'd0;
    push_pass(2);
    pulse_start();
    dchk(busy == 1, "R12 busy after start", int'(busy), 1);
    wait_idle();
    dchk(q.size() == 0, "R3 all slots requested", q.size(), 0);
    dchk(done_flag == 1 && irq == 1, "R9 irq unmasked", int'({done_flag, irq}), 3);
    check_results(2, "R4 result entry");
    clear_done();
    dchk(done_flag == 0 && irq == 0, "R8 cleared by write", int'({done_flag, irq}), 0);

    // Full list, gaps, masked, restart attempt while busy
    stop_idx = 3'd7; dly_first = 4'd0; dly_gap = 4'd2; done_mask = 1'b1;
    push_pass(7);
    pulse_start();
    while (!conv_req) @(negedge clk);
    pulse_start();  // R10: must be ignored
    wait_idle();
    dchk(q.size() == 0, "R12 eight slots converted", q.size(), 0);
    dchk(done_flag == 1 && irq == 0, "R9 irq masked", int'({done_flag, irq}), 2);
    check_results(7, "R4 R12 all results");
    clear_done();
    done_mask = 1'b0;

    // Continuous loop, three passes, flag cleared after each pass
    stop_idx = 3'd1; dly_gap = 4'd1; dly_tail = 4'd2; continuous = 1'b1;
    auto_clr = 1;
    push_pass(1); push_pass(1); push_pass(1);
    pulse_start();
    while (q.size() != 0) @(negedge clk);
    continuous = 1'b0;
    wait_idle();
    dchk(busy == 0, "R7 idle after continuous cleared", int'(busy), 0);
    repeat (200) @(negedge clk);
    auto_clr = 0;
    clear_done();

    // Set and clear in the same cycle
    stop_idx = 3'd0; collide = 1;
    push_pass(0);
    pulse_start();
    wait_idle();
    repeat (2) @(negedge clk);
    collide = 0;
    dchk(done_flag == 1, "R8 set wins over clear", int'(done_flag), 1);
    clear_done();

    // Abort during the start delay
    stop_idx = 3'd3; dly_first = 4'd3;
    pulse_start();
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    dchk(busy == 0 && conv_req == 0, "R11 abort idles", int'({busy, conv_req}), 0);
    repeat (300) @(negedge clk);
    dchk(done_flag == 0, "R11 abort leaves done clear", int'(done_flag), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             drv_cmp + mon_cmp, drv_bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             drv_cmp + mon_cmp + 1, drv_bad + mon_bad + 1);
    $finish;
  end
endmodule